// File: doc/BRIEF.md
# Word-at-a-time CRC-32 engine using Barrett reduction

This block computes a 32-bit cyclic redundancy check over a message that arrives as a stream of 32-bit words. It does not step a shift register once per bit. It folds a whole word into the running remainder with two carry-less (GF(2)) multiplications. The first multiply is by a precomputed reciprocal of the generator polynomial. The second multiply is by the polynomial itself. Together they replace the division whose remainder is the CRC.

Words enter through a valid/ready handshake. A start flag clears the remainder before its word is folded in. A last flag marks the final word of a message. Each accepted word occupies the single shared multiplier for two cycles, so the block drops ready for one cycle after every acceptance. After the last word the block pulses done and holds the finished CRC on its output.

Top module: `crc_barrett_word`

## Requirements
- R1: While reset is held and right after it is released, `in_ready` is 1, `crc_done` is 0 and `crc_out` is 0.
- R2: The message byte order within a word is fixed. `in_data[7:0]` is the first message byte and `in_data[31:24]` is the last. Each byte is taken most significant bit first.
- R3: The result equals a bit-serial CRC over the message bits with generator 0x814141AB (implicit x^32 term), initial value 0, no reflection and no final XOR. For each bit the model shifts the remainder left and XORs in the generator when the old top bit XOR the message bit is 1.
- R4: A word accepted with `in_first` high starts from a zero remainder, whatever came before it. A word accepted with `in_first` low continues from the remainder left by the previous word.
- R5: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for exactly the one cycle after an acceptance and 1 again in the cycle after that.
- R6: `crc_done` is 1 for exactly one cycle. That cycle is the one right after the stall cycle of a word accepted with `in_last` high.
- R7: `crc_out` changes only in the cycle where `crc_done` rises. It holds the last finished CRC until the next message completes.
- R8: Values on `in_valid`, `in_data`, `in_first` and `in_last` during a cycle where `in_ready` is 0 are not consumed and do not affect any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_data` is offered |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 32 | Message word, first byte in bits 7:0 |
| in_first | input | 1 | Clear the remainder before this word |
| in_last | input | 1 | This word ends the message |
| crc_out | output | 32 | Finished CRC, held between completions |
| crc_done | output | 1 | One-cycle pulse when `crc_out` is updated |

## Verification
The bench drives valid high during the stall cycle with junk data and start/last flags. A design that took input while not ready would absorb that junk and corrupt the CRC. It also sends back-to-back messages with and without the start flag. A remainder that failed to clear, or one that was cleared when it should carry over, would give a wrong CRC on the second message. Single-word messages of all zeros and of one nonzero byte in each lane check the byte reversal. A swapped or unswapped lane produces a CRC different from the bit-serial model. The done pulse and the output hold are compared every cycle, so an early, late or doubled pulse shows up directly.

// File: rtl/crc_barrett_word.sv
module crc_barrett_word #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h814141AB,
  parameter logic [W-1:0] MU1  = 32'hFF7FBFB1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_first,
  input  logic         in_last,
  output logic [W-1:0] crc_out,
  output logic         crc_done
);
  localparam int NB = W / 8;
  localparam int PW = 2 * W - 1;

  logic         busy, last_q;
  logic [W-1:0] rem, q, swapped, mix, mul_a, mul_b, hi_rev, lo;
  logic [PW-1:0] pp  [W];
  logic [PW-1:0] acc [W+1];

  for (genvar k = 0; k < NB; k++) begin : g_swap
    assign swapped[8*k +: 8] = in_data[W-1-8*k -: 8];
  end

  assign mix   = (in_first ? '0 : rem) ^ swapped;
  assign mul_a = busy ? q : mix;
  assign mul_b = busy ? POLY : MU1;

  assign acc[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_clmul
    assign pp[i]    = mul_b[i] ? ({{(W-1){1'b0}}, mul_a} << i) : '0;
    assign acc[i+1] = acc[i] ^ pp[i];
  end

  assign hi_rev   = acc[W][PW-1 -: W];
  assign lo       = acc[W][W-1:0];
  assign in_ready = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      last_q   <= 1'b0;
      rem      <= '0;
      q        <= '0;
      crc_out  <= '0;
      crc_done <= 1'b0;
    end else begin
      crc_done <= 1'b0;
      if (busy) begin
        rem  <= lo;
        busy <= 1'b0;
        if (last_q) begin
          crc_out  <= lo;
          crc_done <= 1'b1;
        end
      end else if (in_valid) begin
        q      <= hi_rev;
        last_q <= in_last;
        busy   <= 1'b1;
      end
    end
  end
endmodule

module crc_barrett_word_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic [W-1:0] crc_out,
  input logic         crc_done
);
  p_stall_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_stall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |=> !crc_done);
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(in_valid && in_ready && in_last, 2));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_out) |-> crc_done);
endmodule

bind crc_barrett_word crc_barrett_word_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .crc_out(crc_out), .crc_done(crc_done)
);

// File: tb/test_crc_barrett_word.sv
`timescale 1ns/1ps
module test_crc_barrett_word;
  localparam logic [31:0] POLY = 32'h814141AB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, crc_done;
  logic [31:0] crc_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  crc_barrett_word i_crc_barrett_word (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .crc_out(crc_out), .crc_done(crc_done));

  function automatic logic [31:0] serial_word(input logic [31:0] c, input logic [31:0] d);
    for (int k = 0; k < 4; k++)
      for (int j = 7; j >= 0; j--) begin
        logic fb;
        fb = c[31] ^ d[8*k + j];
        c  = c << 1;
        if (fb) c = c ^ POLY;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-level behavioural reference
  logic        exp_rdy = 1'b1, exp_done = 1'b0;
  logic [31:0] exp_out = '0, mrem = '0;
  bit          pend_last = 0, compare_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_rdy <= 1'b1; exp_done <= 1'b0; exp_out <= '0; mrem = '0; pend_last = 0;
    end else begin
      exp_done <= 1'b0;
      if (!exp_rdy) begin
        exp_rdy <= 1'b1;
        if (pend_last) begin exp_out <= mrem; exp_done <= 1'b1; end
      end else if (in_valid) begin
        mrem      = serial_word(in_first ? 32'h0 : mrem, in_data);
        pend_last = in_last;
        exp_rdy  <= 1'b0;
      end
    end
  end

  always @(negedge clk) if (rst_n && compare_on) begin
    check(in_ready === exp_rdy, "R5/R8 ready", {31'b0, in_ready}, {31'b0, exp_rdy});
    check(crc_done === exp_done, "R6 done", {31'b0, crc_done}, {31'b0, exp_done});
    check(crc_out === exp_out, "R7/R3 crc_out", crc_out, exp_out);
  end

  task automatic send(input logic [31:0] d, input bit first, input bit last, input bit junk);
    bit acc;
    in_valid = 1'b1; in_data = d; in_first = first; in_last = last;
    do begin acc = in_ready; @(posedge clk); #1; end while (!acc);
    if (junk) begin
      in_valid = 1'b1; in_data = $urandom; in_first = 1'b1; in_last = 1'b1;  // R8 stall-cycle junk
    end else in_valid = 1'b0;
  endtask

  logic [31:0] w [16];

  task automatic run_msg(input int n, input bit junk, input bit gaps, input string tag);
    logic [31:0] e = '0;
    for (int i = 0; i < n; i++) begin
      e = serial_word(e, w[i]);
      send(w[i], i == 0, i == n - 1, junk);
      if (gaps && (i % 2 == 0)) begin @(posedge clk); #1; in_valid = 1'b0; @(posedge clk); #1; end
    end
    if (!gaps || ((n - 1) % 2 != 0)) begin @(posedge clk); #1; end
    else begin end
    in_valid = 1'b0;
    if (gaps && ((n - 1) % 2 == 0)) begin
      check(crc_out === e, {tag, " R3 result"}, crc_out, e);
    end else begin
      check(crc_done === 1'b1, {tag, " R6 done"}, {31'b0, crc_done}, 32'h1);
      check(crc_out === e, {tag, " R3 result"}, crc_out, e);
    end
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r1, r2;
    repeat (3) @(posedge clk); #1;
    check(in_ready === 1'b1 && crc_done === 1'b0, "R1 idle in reset", {30'b0, in_ready, crc_done}, 32'h2);
    check(crc_out === 32'h0, "R1 crc_out reset", crc_out, 32'h0);
    rst_n = 1'b1; compare_on = 1;
    @(posedge clk); #1;
    check(in_ready === 1'b1 && crc_done === 1'b0 && crc_out === 0, "R1 after release", crc_out, 32'h0);

    w[0] = 32'h0;          run_msg(1, 0, 0, "zero word");
    for (int b = 0; b < 4; b++) begin
      w[0] = 32'hA5 << (8 * b); run_msg(1, 0, 0, "R2 byte lane");
    end
    w[0] = 32'h12345678;   run_msg(1, 1, 0, "single");
    for (int i = 0; i < 4; i++) w[i] = 32'h01020304 * (i + 1);
    run_msg(4, 0, 0, "four words");
    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < 16; i++) w[i] = $urandom;
      run_msg(3 + m * 2, m % 2 == 1, m % 3 == 2, "random");
    end

    // R4: first word clears, same message gives same result
    for (int i = 0; i < 5; i++) w[i] = 32'hC0DE0000 + i;
    run_msg(5, 0, 0, "R4 pass A"); r1 = crc_out;
    w[0] = 32'hFFFFFFFF; run_msg(1, 0, 0, "R4 disturb");
    for (int i = 0; i < 5; i++) w[i] = 32'hC0DE0000 + i;
    run_msg(5, 1, 0, "R4 pass B"); r2 = crc_out;
    check(r1 === r2, "R4 repeat equal", r2, r1);

    // R4: continue without in_first after a finished message
    send(32'h11111111, 1, 1, 0); send(32'h22222222, 0, 1, 0);
    @(posedge clk); #1;
    r1 = serial_word(serial_word(32'h0, 32'h11111111), 32'h22222222);
    check(crc_out === r1, "R4 chained remainder", crc_out, r1);
    repeat (4) @(posedge clk); #1;
    check(crc_out === r1, "R7 hold", crc_out, r1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule